// File: doc/BRIEF.md
# Virtual Address Translation Front-End

This block turns a 32-bit virtual address into a 29-bit physical address for one access per cycle. The top three address bits select a region. Two regions map straight onto physical memory by dropping those three bits. Two regions are looked up in a small fully associative translation buffer. The top region is the on-chip control space, and its addresses are never translated. Instruction fetches search an instruction buffer, and data accesses search a separate data buffer. A user-mode access to any region with address bit 31 set is refused.

The physical space is divided into eight 64 MB areas, and each result carries its area number. Area 7 is reserved when it is reached by direct mapping. When a buffer translation lands in area 7, the access is sent to the control space instead. Buffer entries are written by index through a load port, which stands in for a software refill after a miss. Every result appears on registered outputs one clock after the request.

Top module: `vat_xlate`

## Requirements
- R1: After reset every response output is 0 and every buffer entry in both buffers is invalid, so the first lookup misses.
- R2: A request with `req_user`=1 and `req_vaddr[31]`=1 gives `rsp_addr_err`=1 with paddr 0 and no other outcome flag. A user request to `req_vaddr[31:29]` from 0 to 3 is translated normally.
- R3: When `req_vaddr[31:29]` is 4 or 5, paddr equals `req_vaddr[28:0]` and no buffer is consulted.
- R4: When `req_vaddr[31:29]` is 7, the response has `rsp_ctrl`=1 and paddr `req_vaddr[28:0]`, even if a buffer entry would match.
- R5: When `req_vaddr[31:29]` is 0 to 3 or 6 and a valid entry's 20-bit page number equals `req_vaddr[31:12]`, paddr is {entry's 17-bit frame, `req_vaddr[11:0]`}.
- R6: A buffer lookup with no valid match gives `rsp_tlb_miss`=1, paddr 0, and `rsp_mem`=0.
- R7: Requests with `req_is_fetch`=1 search only the instruction buffer, and others search only the data buffer. A load with `ld_itlb`=1 writes only the instruction buffer.
- R8: A load changes lookups from the next cycle on. A request in the same cycle as the load sees the old contents. A load with `ld_entry_valid`=0 invalidates that index.
- R9: `rsp_area` is paddr[28:26]. A buffer translation into area 7 gives `rsp_ctrl`=1 instead of `rsp_mem`.
- R10: A direct-mapped request whose paddr falls in area 7 gives `rsp_reserved`=1 and `rsp_mem`=0.
- R11: Results appear on the first rising edge after the request, and exactly one of mem, ctrl, miss, addr_err and reserved is set. A cycle without a request gives all outputs 0.
- R12: When several valid entries match, the lowest index supplies the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| ld_valid | input | 1 | Write one buffer entry |
| ld_itlb | input | 1 | 1 = instruction buffer, 0 = data buffer |
| ld_index | input | 2 | Entry index to write |
| ld_entry_valid | input | 1 | Valid bit written to the entry |
| ld_vpn | input | 20 | Virtual page number written |
| ld_ppn | input | 17 | Physical frame number written |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 29 | Physical address |
| rsp_area | output | 3 | Physical area number |
| rsp_mem | output | 1 | Memory access issued |
| rsp_ctrl | output | 1 | Control-space access |
| rsp_tlb_miss | output | 1 | Buffer miss |
| rsp_addr_err | output | 1 | Privilege violation |
| rsp_reserved | output | 1 | Direct access to reserved area 7 |

## Verification
Every response is due on the first rising edge after the request. The bench drives each request at a falling edge and samples 2 ns after the next rising edge. It then drops `req_valid` before the edge that follows, so the idle check really sees a cycle with no request. A load is written at the rising edge that follows the falling edge where it is driven. Requests issued after that edge must see the new entry, and the bench also places one request on the same edge as a load to check that the old contents are used.

// File: rtl/vat_pkg.sv
package vat_pkg;
  // Virtual regions selected by the top three address bits
  typedef enum logic [2:0] {
    RGN_LOW      = 3'd0,  // translated, user reachable
    RGN_LINEAR_C = 3'd1,  // direct map
    RGN_LINEAR_U = 3'd2,  // direct map
    RGN_KMAP     = 3'd3,  // translated, privileged
    RGN_CTRL     = 3'd4   // control space, untranslated
  } rgn_e;
endpackage

// File: rtl/vat_region_decode.sv
module vat_region_decode
  import vat_pkg::*;
(
  input  logic [2:0] top_bits,
  input  logic       user_mode,
  output logic       use_tlb,
  output logic       use_direct,
  output logic       use_ctrl,
  output logic       priv_fault
);
  rgn_e rgn;

  always_comb begin
    case (top_bits)
      3'd4:    rgn = RGN_LINEAR_C;
      3'd5:    rgn = RGN_LINEAR_U;
      3'd6:    rgn = RGN_KMAP;
      3'd7:    rgn = RGN_CTRL;
      default: rgn = RGN_LOW;
    endcase
  end

  assign priv_fault = user_mode && top_bits[2];
  assign use_tlb    = (rgn == RGN_LOW) || (rgn == RGN_KMAP);
  assign use_direct = (rgn == RGN_LINEAR_C) || (rgn == RGN_LINEAR_U);
  assign use_ctrl   = (rgn == RGN_CTRL);
endmodule

// File: rtl/vat_tlb.sv
module vat_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 17,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn
);
  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  // Only the valid bits need a reset; tag and frame storage stays reset-free
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (vpn_q[g] == lk_vpn);
  end

  // Scan from the top so the lowest matching index is the last to win
  always_comb begin
    lk_hit = |match;
    lk_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) lk_ppn = ppn_q[i];
    end
  end
endmodule

// File: rtl/vat_area_decode.sv
module vat_area_decode #(
  parameter int AREA_W = 3
) (
  input  logic [AREA_W-1:0] area_bits,
  output logic [AREA_W-1:0] area,
  output logic              area_top
);
  assign area     = area_bits;
  assign area_top = &area_bits;
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 29,
  parameter int PAGE_W      = 12,
  parameter int TLB_ENTRIES = 4,
  localparam int VPN_W      = VA_W - PAGE_W,
  localparam int PPN_W      = PA_W - PAGE_W,
  localparam int AREA_W     = 3,
  localparam int IDX_W      = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_is_fetch,
  input  logic              req_user,
  input  logic              ld_valid,
  input  logic              ld_itlb,
  input  logic [IDX_W-1:0]  ld_index,
  input  logic              ld_entry_valid,
  input  logic [VPN_W-1:0]  ld_vpn,
  input  logic [PPN_W-1:0]  ld_ppn,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [AREA_W-1:0] rsp_area,
  output logic              rsp_mem,
  output logic              rsp_ctrl,
  output logic              rsp_tlb_miss,
  output logic              rsp_addr_err,
  output logic              rsp_reserved
);
  logic use_tlb, use_direct, use_ctrl, priv_fault;

  vat_region_decode u_rgn (
    .top_bits   (req_vaddr[VA_W-1 -: 3]),
    .user_mode  (req_user),
    .use_tlb    (use_tlb),
    .use_direct (use_direct),
    .use_ctrl   (use_ctrl),
    .priv_fault (priv_fault)
  );

  // Index 0 = data buffer, index 1 = instruction buffer
  logic             tlb_hit [2];
  logic [PPN_W-1:0] tlb_ppn [2];

  for (genvar t = 0; t < 2; t++) begin : g_tlb
    vat_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
    ) u_tlb (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (ld_valid && (ld_itlb == 1'(t))),
      .wr_idx   (ld_index),
      .wr_valid (ld_entry_valid),
      .wr_vpn   (ld_vpn),
      .wr_ppn   (ld_ppn),
      .lk_vpn   (req_vaddr[VA_W-1:PAGE_W]),
      .lk_hit   (tlb_hit[t]),
      .lk_ppn   (tlb_ppn[t])
    );
  end

  logic             sel_hit;
  logic [PA_W-1:0]  direct_pa, tlb_pa, cand_pa;
  logic [AREA_W-1:0] cand_area;
  logic             cand_top;

  assign sel_hit   = tlb_hit[req_is_fetch];
  assign direct_pa = req_vaddr[PA_W-1:0];
  assign tlb_pa    = {tlb_ppn[req_is_fetch], req_vaddr[PAGE_W-1:0]};
  assign cand_pa   = use_tlb ? tlb_pa : direct_pa;

  vat_area_decode #(.AREA_W(AREA_W)) u_area (
    .area_bits (cand_pa[PA_W-1 -: AREA_W]),
    .area      (cand_area),
    .area_top  (cand_top)
  );

  logic              n_valid, n_mem, n_ctrl, n_miss, n_aerr, n_rsvd;
  logic [PA_W-1:0]   n_paddr;
  logic [AREA_W-1:0] n_area;

  always_comb begin
    n_valid = 1'b0;
    n_mem   = 1'b0;
    n_ctrl  = 1'b0;
    n_miss  = 1'b0;
    n_aerr  = 1'b0;
    n_rsvd  = 1'b0;
    n_paddr = '0;
    n_area  = '0;
    if (req_valid) begin
      n_valid = 1'b1;
      if (priv_fault) begin
        n_aerr = 1'b1;
      end else if (use_ctrl) begin
        n_ctrl  = 1'b1;
        n_paddr = cand_pa;
        n_area  = cand_area;
      end else if (use_direct) begin
        n_paddr = cand_pa;
        n_area  = cand_area;
        n_rsvd  = cand_top;
        n_mem   = !cand_top;
      end else if (sel_hit) begin
        n_paddr = cand_pa;
        n_area  = cand_area;
        n_ctrl  = cand_top;   // top area via translation reaches control space
        n_mem   = !cand_top;
      end else begin
        n_miss = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_area     <= '0;
      rsp_mem      <= 1'b0;
      rsp_ctrl     <= 1'b0;
      rsp_tlb_miss <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_reserved <= 1'b0;
    end else begin
      rsp_valid    <= n_valid;
      rsp_paddr    <= n_paddr;
      rsp_area     <= n_area;
      rsp_mem      <= n_mem;
      rsp_ctrl     <= n_ctrl;
      rsp_tlb_miss <= n_miss;
      rsp_addr_err <= n_aerr;
      rsp_reserved <= n_rsvd;
    end
  end
endmodule

// File: rtl/vat_xlate_chk.sv
module vat_xlate_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 29
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_user,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_area,
  input logic            rsp_mem,
  input logic            rsp_ctrl,
  input logic            rsp_tlb_miss,
  input logic            rsp_addr_err,
  input logic            rsp_reserved
);
  // R11: one outcome per response
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_mem, rsp_ctrl, rsp_tlb_miss, rsp_addr_err, rsp_reserved}) == 1);

  // R11: quiet outputs on idle cycles
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_mem || rsp_ctrl || rsp_tlb_miss || rsp_addr_err || rsp_reserved));

  // R11: response follows request by one edge
  a_r11_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2: privilege violation
  a_r2_user_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && req_vaddr[VA_W-1]) |=> rsp_addr_err);

  // R3: direct mapping drops the region bits
  a_r3_direct_map: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_user && req_vaddr[VA_W-1 -: 2] == 2'b10)
      |=> (rsp_paddr == $past(req_vaddr[PA_W-1:0])) && !rsp_tlb_miss);

  // R4: control space is never translated
  a_r4_ctrl_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_user && req_vaddr[VA_W-1 -: 3] == 3'd7)
      |=> rsp_ctrl && (rsp_paddr == $past(req_vaddr[PA_W-1:0])));

  // R6: a miss carries no address
  a_r6_miss_no_addr: assert property (@(posedge clk) disable iff (rst)
    rsp_tlb_miss |-> (rsp_paddr == '0) && !rsp_mem);

  // R9: area number tracks the physical address
  a_r9_area_bits: assert property (@(posedge clk) disable iff (rst)
    (rsp_mem || rsp_ctrl || rsp_reserved) |-> rsp_area == rsp_paddr[PA_W-1 -: 3]);

  // R10: memory accesses never land in the top area
  a_r10_mem_not_top: assert property (@(posedge clk) disable iff (rst)
    rsp_mem |-> rsp_area != 3'd7);
endmodule

bind vat_xlate vat_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_user     (req_user),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_area     (rsp_area),
  .rsp_mem      (rsp_mem),
  .rsp_ctrl     (rsp_ctrl),
  .rsp_tlb_miss (rsp_tlb_miss),
  .rsp_addr_err (rsp_addr_err),
  .rsp_reserved (rsp_reserved)
);

// File: tb/vat_xlate_test.sv
module vat_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_is_fetch = 1'b0;
  logic        req_user = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_itlb = 1'b0;
  logic [1:0]  ld_index = '0;
  logic        ld_entry_valid = 1'b0;
  logic [19:0] ld_vpn = '0;
  logic [16:0] ld_ppn = '0;
  logic        rsp_valid;
  logic [28:0] rsp_paddr;
  logic [2:0]  rsp_area;
  logic        rsp_mem, rsp_ctrl, rsp_tlb_miss, rsp_addr_err, rsp_reserved;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // flags: {valid, mem, ctrl, miss, addr_err, reserved}
  localparam logic [5:0] F_NONE = 6'b000000;
  localparam logic [5:0] F_MEM  = 6'b110000;
  localparam logic [5:0] F_CTRL = 6'b101000;
  localparam logic [5:0] F_MISS = 6'b100100;
  localparam logic [5:0] F_AERR = 6'b100010;
  localparam logic [5:0] F_RSVD = 6'b100001;

  always #4 clk = ~clk;  // 125 MHz

  vat_xlate uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_is_fetch(req_is_fetch), .req_user(req_user),
    .ld_valid(ld_valid), .ld_itlb(ld_itlb), .ld_index(ld_index),
    .ld_entry_valid(ld_entry_valid), .ld_vpn(ld_vpn), .ld_ppn(ld_ppn),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_area(rsp_area),
    .rsp_mem(rsp_mem), .rsp_ctrl(rsp_ctrl), .rsp_tlb_miss(rsp_tlb_miss),
    .rsp_addr_err(rsp_addr_err), .rsp_reserved(rsp_reserved)
  );

  task automatic expect_rsp(string tag, logic [5:0] fl, logic [2:0] area, logic [28:0] pa);
    logic [37:0] got, exp;
    got = {rsp_valid, rsp_mem, rsp_ctrl, rsp_tlb_miss, rsp_addr_err, rsp_reserved, rsp_area, rsp_paddr};
    exp = {fl, area, pa};
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got flags=%b area=%0d pa=%h, expected flags=%b area=%0d pa=%h",
               tag, got[37:32], got[31:29], got[28:0], fl, area, pa);
    end
  endtask

  // Issue one request; sample just after the edge that registers it
  task automatic issue(logic [31:0] va, logic fetch, logic user);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_is_fetch = fetch; req_user = user;
    @(posedge clk);
    #2;
    req_valid = 1'b0;
  endtask

  task automatic load(logic itlb, logic [1:0] idx, logic vld, logic [19:0] vpn, logic [16:0] ppn);
    @(negedge clk);
    ld_valid = 1'b1; ld_itlb = itlb; ld_index = idx;
    ld_entry_valid = vld; ld_vpn = vpn; ld_ppn = ppn;
    @(posedge clk);
    #2;
    ld_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_rsp("R1 outputs after reset", F_NONE, 3'd0, 29'h0);
    issue(32'h0000_1000, 1'b1, 1'b0);
    expect_rsp("R1 fetch lookup after reset misses", F_MISS, 3'd0, 29'h0);
    issue(32'h0000_1000, 1'b0, 1'b0);
    expect_rsp("R1 data lookup after reset misses", F_MISS, 3'd0, 29'h0);
  endtask

  task automatic t_idle;
    issue(32'h8000_0040, 1'b0, 1'b0);
    @(posedge clk);
    #2;
    expect_rsp("R11 idle cycle clears outputs", F_NONE, 3'd0, 29'h0);
  endtask

  task automatic t_direct;
    issue(32'h8123_4567, 1'b0, 1'b0);
    expect_rsp("R3 region 4 direct", F_MEM, 3'd0, 29'h0123_4567);
    issue(32'hA800_0010, 1'b1, 1'b0);
    expect_rsp("R3 R9 region 5 direct area 2", F_MEM, 3'd2, 29'h0800_0010);
    issue(32'h9C00_0004, 1'b0, 1'b0);
    expect_rsp("R10 direct into area 7 reserved", F_RSVD, 3'd7, 29'h1C00_0004);
  endtask

  task automatic t_ctrl;
    load(1'b0, 2'd0, 1'b1, 20'hFF000, 17'h00001);
    issue(32'hFF00_0010, 1'b0, 1'b0);
    expect_rsp("R4 control region ignores matching entry", F_CTRL, 3'd7, 29'h1F00_0010);
  endtask

  task automatic t_user;
    issue(32'h8000_0000, 1'b0, 1'b1);
    expect_rsp("R2 user to region 4", F_AERR, 3'd0, 29'h0);
    issue(32'hC000_1ABC, 1'b0, 1'b1);
    expect_rsp("R2 user to region 6", F_AERR, 3'd0, 29'h0);
    load(1'b0, 2'd1, 1'b1, 20'h00000, 17'h00022);
    issue(32'h0000_0ABC, 1'b0, 1'b1);
    expect_rsp("R2 user to region 0 translates", F_MEM, 3'd0, 29'h0002_2ABC);
  endtask

  task automatic t_tlb;
    load(1'b0, 2'd0, 1'b1, 20'h12345, 17'h00ABC);
    issue(32'h1234_5678, 1'b0, 1'b0);
    expect_rsp("R5 data hit", F_MEM, 3'd0, 29'h00AB_C678);
    issue(32'h1234_5678, 1'b1, 1'b0);
    expect_rsp("R7 fetch ignores data buffer", F_MISS, 3'd0, 29'h0);
    load(1'b1, 2'd1, 1'b1, 20'h12345, 17'h04000);
    issue(32'h1234_5678, 1'b1, 1'b0);
    expect_rsp("R7 fetch hit in instruction buffer", F_MEM, 3'd1, 29'h0400_0678);
    issue(32'h1234_5678, 1'b0, 1'b0);
    expect_rsp("R7 data still uses its own entry", F_MEM, 3'd0, 29'h00AB_C678);
    load(1'b0, 2'd2, 1'b1, 20'hC0001, 17'h1C000);
    issue(32'hC000_1ABC, 1'b0, 1'b0);
    expect_rsp("R9 translated area 7 goes to control", F_CTRL, 3'd7, 29'h1C00_0ABC);
  endtask

  task automatic t_load_timing;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_5000; req_is_fetch = 1'b0; req_user = 1'b0;
    ld_valid = 1'b1; ld_itlb = 1'b0; ld_index = 2'd3; ld_entry_valid = 1'b1;
    ld_vpn = 20'h00005; ld_ppn = 17'h00300;
    @(posedge clk);
    #2;
    req_valid = 1'b0; ld_valid = 1'b0;
    expect_rsp("R8 same-cycle load not yet visible", F_MISS, 3'd0, 29'h0);
    issue(32'h0000_5000, 1'b0, 1'b0);
    expect_rsp("R8 load visible next cycle", F_MEM, 3'd0, 29'h0030_0000);
    load(1'b0, 2'd3, 1'b0, 20'h00005, 17'h00300);
    issue(32'h0000_5000, 1'b0, 1'b0);
    expect_rsp("R8 R6 invalidated entry misses", F_MISS, 3'd0, 29'h0);
  endtask

  task automatic t_prio;
    load(1'b0, 2'd1, 1'b1, 20'h00777, 17'h00200);
    load(1'b0, 2'd0, 1'b1, 20'h00777, 17'h00100);
    issue(32'h0077_7123, 1'b0, 1'b0);
    expect_rsp("R12 lowest index wins", F_MEM, 3'd0, 29'h0010_0123);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    t_reset();
    t_idle();
    t_direct();
    t_ctrl();
    t_user();
    t_tlb();
    t_load_timing();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule